// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a general-purpose I/O controller for up to 32 pins. A simple 32-bit register bus drives it, with an address, a write enable, write data and read data. Software sets each pin as an input or an output, drives output levels, and reads back the state of every pin. Each pin sits behind a two-flop synchronizer. Each pin can also raise an interrupt on a high level, a low level, a rising edge, a falling edge, or either edge.

Events are latched in a pending register that software clears by writing ones. A per-pin enable masks the pending bits. One registered interrupt line is raised while any enabled pending bit is set. A read-only version word tells software whether the either-edge trigger is built in.

The register bus has no handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr` and is valid in the same cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the following registers read zero: enable, output value, edge select, both-edges select and pending. Direction and polarity read all ones within the pin range. Every pin is then an input (`pin_oe` low) and `irq_o` is low.
- R2: Direction is at byte offset 0x04. A bit of 1 makes the pin an input and a bit of 0 makes it an output. An output pin has `pin_oe` high and drives `pin_out` from the value register at 0x00. Reading 0x00 returns the synchronized pin for input pins and the stored value for output pins. A pin change shows in this read two clock edges after it is sampled.
- R3: An edge-select bit of 0 (offset 0x18) makes the pin level-sensitive. The polarity bit (offset 0x1C) then picks the active level: 1 for high, 0 for low. The pending bit is set again on every cycle that the active level persists, so a clear issued while the level is held does not stick.
- R4: An edge-select bit of 1 with the both-edges bit (offset 0x24) at 0 gives edge triggering. A polarity bit of 1 picks the rising edge and 0 picks the falling edge. The pending bit (offset 0x10) is set one edge after the synchronized sample changes, and it holds until cleared.
- R5: An edge-select bit of 1 together with a both-edges bit of 1 triggers on either edge. This applies only when the version parameter is 3 or more.
- R6: Writing 1 to a bit at offset 0x14 clears that pending bit. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins over the clear.
- R7: Reading offset 0x0C returns the pending bits ANDed with the enables at 0x08. `irq_o` is the OR of that value, registered, so it follows the pending and enable state by one clock.
- R8: Offset 0x20 reads the version parameter (default 3). Writes to 0x0C, 0x10 and 0x20 are ignored. Offset 0x14 and unmapped offsets read zero.
- R9: Register bits at or above the pin count are not stored and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | N | Asynchronous pin levels from the pads |
| pin_out | output | N | Output levels toward the pads |
| pin_oe | output | N | Output enable per pin, high for outputs |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a clear that lands in the same cycle as a fresh event. The second is a clear written while a level trigger is still active. In both cases the pending bit must survive, and the three-stage input pipeline makes the timing of that collision hard to predict by hand. Directed steps hold a level-high pin while clearing it, which reaches the second case deterministically. A long stretch of random pin toggling mixed with random register writes, including many clears, makes the same-cycle collision occur for both edge and level triggers. A behavioural model compares every output and the addressed read word on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_DATA  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_DIR   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_IEN   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_ISTAT = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_IPEND = 6'h10;
  localparam logic [REG_AW-1:0] OFS_ICLR  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_MODE  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_POL   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_VER   = 6'h20;
  localparam logic [REG_AW-1:0] OFS_DUAL  = 6'h24;

  typedef enum logic [2:0] {
    TRG_LOW, TRG_HIGH, TRG_FALL, TRG_RISE, TRG_ANY
  } trig_e;

  function automatic trig_e trig_decode(input logic edge_sel, input logic pol,
                                        input logic dual, input logic dual_ok);
    if (!edge_sel)           return pol ? TRG_HIGH : TRG_LOW;
    else if (dual && dual_ok) return TRG_ANY;
    else                     return pol ? TRG_RISE : TRG_FALL;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_dly_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      q_o     <= '0;
      q_dly_o <= '0;
    end else begin
      meta_q  <= d_i;
      q_o     <= meta_q;
      q_dly_o <= q_o;
    end
  end
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_irq_pkg::*;
#(
  parameter bit DUAL_OK = 1'b1
) (
  input  logic cur_i,
  input  logic prv_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic dual_i,
  output logic hit_o
);
  trig_e mode;

  always_comb begin
    mode = trig_decode(edge_i, pol_i, dual_i, DUAL_OK);
    unique case (mode)
      TRG_HIGH: hit_o = cur_i;
      TRG_LOW:  hit_o = ~cur_i;
      TRG_RISE: hit_o = cur_i & ~prv_i;
      TRG_FALL: hit_o = ~cur_i & prv_i;
      TRG_ANY:  hit_o = cur_i ^ prv_i;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= (pend_o & ~clr_i) | hit_i;
      irq_o  <= |(pend_o & en_i);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N       = 32,
  parameter int unsigned VERSION = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq_o
);
  localparam bit DUAL_OK = (VERSION >= 3);

  logic [N-1:0] out_q, dir_q, en_q, sel_q, pol_q, dual_q;
  logic [N-1:0] pin_s, pin_d, hit_w, pend_q, clr_w, wbits;

  function automatic logic [31:0] zx(input logic [N-1:0] v);
    logic [31:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  assign wbits = bus_wdata[N-1:0];
  assign clr_w = (bus_we && bus_addr == OFS_ICLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      en_q   <= '0;
      sel_q  <= '0;
      pol_q  <= '1;
      dual_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_DATA: out_q  <= wbits;
        OFS_DIR:  dir_q  <= wbits;
        OFS_IEN:  en_q   <= wbits;
        OFS_MODE: sel_q  <= wbits;
        OFS_POL:  pol_q  <= wbits;
        OFS_DUAL: dual_q <= wbits;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(N)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_i     (pin_in),
    .q_o     (pin_s),
    .q_dly_o (pin_d)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpio_trig_cell #(.DUAL_OK(DUAL_OK)) trig_i (
      .cur_i  (pin_s[g]),
      .prv_i  (pin_d[g]),
      .edge_i (sel_q[g]),
      .pol_i  (pol_q[g]),
      .dual_i (dual_q[g]),
      .hit_o  (hit_w[g])
    );
  end

  gpio_pend_bank #(.W(N)) pend_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit_w),
    .clr_i  (clr_w),
    .en_i   (en_q),
    .pend_o (pend_q),
    .irq_o  (irq_o)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    case (bus_addr)
      OFS_DATA:  bus_rdata = zx((pin_s & dir_q) | (out_q & ~dir_q));
      OFS_DIR:   bus_rdata = zx(dir_q);
      OFS_IEN:   bus_rdata = zx(en_q);
      OFS_ISTAT: bus_rdata = zx(pend_q & en_q);
      OFS_IPEND: bus_rdata = zx(pend_q);
      OFS_MODE:  bus_rdata = zx(sel_q);
      OFS_POL:   bus_rdata = zx(pol_q);
      OFS_VER:   bus_rdata = VERSION;
      OFS_DUAL:  bus_rdata = zx(dual_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N       = 32,
  parameter int unsigned VERSION = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N-1:0]      pin_oe,
  input logic              irq_o,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      hit_w
);
  logic [N-1:0] clr_c;
  assign clr_c = (bus_we && bus_addr == OFS_ICLR) ? bus_wdata[N-1:0] : '0;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend_q & en_q))); // R7

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata[N-1:0]))); // R2

  AST_NO_SPUR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit_w)) == '0)); // R4

  AST_NO_SPUR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q) & ~$past(clr_c)) == '0)); // R6

  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | ~$past(hit_w)) == '1)); // R6

  AST_VER_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VER) |-> (bus_rdata == VERSION)); // R8
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N), .VERSION(VERSION)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .hit_w     (hit_w)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  import gpio_irq_pkg::*;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.N(NP), .VERSION(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // behavioural reference
  logic [NP-1:0] m_out, m_dir, m_en, m_pend, m_sel, m_pol, m_dual;
  logic [NP-1:0] m_q1, m_q2, m_q3, m_hit;
  logic          m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '1; m_en = '0; m_pend = '0; m_sel = '0;
      m_pol = '1; m_dual = '0; m_q1 = '0; m_q2 = '0; m_q3 = '0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (!m_sel[i])     m_hit[i] = m_pol[i] ? m_q2[i] : !m_q2[i];
        else if (m_dual[i]) m_hit[i] = m_q2[i] != m_q3[i];
        else if (m_pol[i])  m_hit[i] = m_q2[i] && !m_q3[i];
        else                m_hit[i] = !m_q2[i] && m_q3[i];
      end
      m_irq = (m_pend & m_en) != 0;
      if (bus_we && bus_addr == OFS_ICLR) m_pend = m_pend & ~bus_wdata[NP-1:0];
      m_pend = m_pend | m_hit;
      if (bus_we) begin
        if (bus_addr == OFS_DATA) m_out  = bus_wdata[NP-1:0];
        if (bus_addr == OFS_DIR)  m_dir  = bus_wdata[NP-1:0];
        if (bus_addr == OFS_IEN)  m_en   = bus_wdata[NP-1:0];
        if (bus_addr == OFS_MODE) m_sel  = bus_wdata[NP-1:0];
        if (bus_addr == OFS_POL)  m_pol  = bus_wdata[NP-1:0];
        if (bus_addr == OFS_DUAL) m_dual = bus_wdata[NP-1:0];
      end
      m_q3 = m_q2; m_q2 = m_q1; m_q1 = pin_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [NP-1:0] v;
    case (a)
      OFS_DATA:  v = (m_q2 & m_dir) | (m_out & ~m_dir);
      OFS_DIR:   v = m_dir;
      OFS_IEN:   v = m_en;
      OFS_ISTAT: v = m_pend & m_en;
      OFS_IPEND: v = m_pend;
      OFS_MODE:  v = m_sel;
      OFS_POL:   v = m_pol;
      OFS_DUAL:  v = m_dual;
      OFS_VER:   return 32'd3;
      default:   v = '0;
    endcase
    return {{(32-NP){1'b0}}, v};
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      OFS_DATA, OFS_DIR:   return "R2";
      OFS_MODE, OFS_POL:   return "R3";
      OFS_DUAL:            return "R5";
      OFS_IPEND:           return "R6";
      OFS_IEN, OFS_ISTAT:  return "R7";
      default:             return "R8";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk({31'b0, irq_o}, {31'b0, m_irq}, "R7");
      chk({24'b0, pin_oe}, {24'b0, ~m_dir}, "R2");
      chk({24'b0, pin_out}, {24'b0, m_out}, "R2");
      chk(bus_rdata, m_read(bus_addr), tag_of(bus_addr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata, e, tag);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    live = 1'b1;
    // R1 reset values
    exp_rd(OFS_DIR,   32'hFF, "R1");
    exp_rd(OFS_POL,   32'hFF, "R1");
    exp_rd(OFS_IEN,   32'h00, "R1");
    exp_rd(OFS_IPEND, 32'h00, "R1");
    exp_rd(OFS_MODE,  32'h00, "R1");
    exp_rd(OFS_DUAL,  32'h00, "R1");
    chk({24'b0, pin_oe}, 32'h0, "R1");
    chk({31'b0, irq_o}, 32'h0, "R1");

    // R2 direction and value readback
    wr(OFS_DIR, 32'hF0);
    wr(OFS_DATA, 32'hA5);
    pin_in = 8'h30;
    tick(3);
    exp_rd(OFS_DATA, 32'h35, "R2");
    chk({24'b0, pin_out}, 32'hA5, "R2");
    chk({24'b0, pin_oe}, 32'h0F, "R2");
    // R9 bits beyond the pin count
    wr(OFS_DATA, 32'hFFFF_FF5A);
    exp_rd(OFS_DATA, 32'h3A, "R9");
    wr(OFS_IEN, 32'hFFFF_FF00);
    exp_rd(OFS_IEN, 32'h00, "R9");
    wr(OFS_DIR, 32'hFF);
    pin_in = 8'h00;
    tick(3);
    wr(OFS_ICLR, 32'hFF);

    // R3 level high persists across clear
    pin_in = 8'h01;
    tick(3);
    exp_rd(OFS_IPEND, 32'h01, "R3");
    wr(OFS_ICLR, 32'h01);
    exp_rd(OFS_IPEND, 32'h01, "R3");
    pin_in = 8'h00;
    tick(3);
    wr(OFS_ICLR, 32'h01);
    exp_rd(OFS_IPEND, 32'h00, "R6");
    // R3 low level
    wr(OFS_POL, 32'hFD);
    tick(2);
    exp_rd(OFS_IPEND, 32'h02, "R3");
    wr(OFS_ICLR, 32'h00);
    exp_rd(OFS_IPEND, 32'h02, "R6");
    wr(OFS_POL, 32'hFF);
    tick(1);
    wr(OFS_ICLR, 32'hFF);
    exp_rd(OFS_IPEND, 32'h00, "R6");

    // R4 rising on pin 2, falling on pin 3
    wr(OFS_MODE, 32'h0C);
    wr(OFS_POL, 32'hF7);
    wr(OFS_ICLR, 32'hFF);
    exp_rd(OFS_IPEND, 32'h00, "R4");
    pin_in = 8'h04; tick(4);
    exp_rd(OFS_IPEND, 32'h04, "R4");
    pin_in = 8'h00; tick(4);
    exp_rd(OFS_IPEND, 32'h04, "R4");
    pin_in = 8'h08; tick(4);
    exp_rd(OFS_IPEND, 32'h04, "R4");
    pin_in = 8'h00; tick(4);
    exp_rd(OFS_IPEND, 32'h0C, "R4");

    // R5 either edge on pin 4
    wr(OFS_MODE, 32'h1C);
    wr(OFS_DUAL, 32'h10);
    wr(OFS_ICLR, 32'hFF);
    pin_in = 8'h10; tick(4);
    exp_rd(OFS_IPEND, 32'h10, "R5");
    wr(OFS_ICLR, 32'h10);
    exp_rd(OFS_IPEND, 32'h00, "R5");
    pin_in = 8'h00; tick(4);
    exp_rd(OFS_IPEND, 32'h10, "R5");

    // R7 masked status and registered interrupt
    wr(OFS_ICLR, 32'hFF);
    wr(OFS_IEN, 32'h04);
    chk({31'b0, irq_o}, 32'h0, "R7");
    pin_in = 8'h04;
    tick(3);
    chk({31'b0, irq_o}, 32'h0, "R7");
    exp_rd(OFS_ISTAT, 32'h04, "R7");
    chk({31'b0, irq_o}, 32'h1, "R7");
    wr(OFS_ICLR, 32'h04);
    chk({31'b0, irq_o}, 32'h1, "R7");
    tick(1);
    chk({31'b0, irq_o}, 32'h0, "R7");

    // R8 read-only words
    wr(OFS_IPEND, 32'hFF);
    wr(OFS_ISTAT, 32'hFF);
    wr(OFS_VER, 32'h77);
    exp_rd(OFS_VER, 32'h3, "R8");
    exp_rd(OFS_ICLR, 32'h0, "R8");
    exp_rd(OFS_IPEND, 32'h0, "R8");
    exp_rd(6'h3C, 32'h0, "R8");

    // mixed traffic, model compared every cycle
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) pin_in = r[15:8];
      if (r[4:3] == 2'd0) begin
        bus_addr = {r[19:16], 2'b00};
        bus_wdata = $urandom;
        bus_we = 1'b1;
      end else begin
        bus_we = 1'b0;
        bus_addr = {r[23:20], 2'b00};
      end
      if (r[26:24] == 3'd1) begin
        bus_addr = OFS_ICLR; bus_wdata = $urandom; bus_we = 1'b1;
      end
      tick(1);
    end
    bus_we = 1'b0;
    tick(2);
    finish_run();
  end
endmodule